// File: doc/BRIEF.md
# Parallel Flash Byte Program Sequencer

This block sits on the host side of a byte-wide asynchronous parallel flash and programs one byte per request. A request carries a target address and a data byte. The block drives the chip-select, read-strobe and write-strobe pins from the system clock. It issues a three-write unlock prefix and then the write of the user byte. It then reads the target address again and again until bit 7 of the returned value equals bit 7 of the written byte. While the flash is busy it returns the inverse of that bit.

Every bus timing is a parameter given in nanoseconds and is turned into whole clock cycles, rounding up. A poll limit bounds the wait. If no read matches within that many reads, the block reports an error instead of completion.

Requests use a valid/ready handshake. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Ready stays low from acceptance until the cycle the outcome is reported, so a source holding valid simply waits. A valid raised while ready is low is never taken.

Top module: `flash_prog_seq`

## Requirements
- R1: Out of reset and whenever idle, `req_ready` is 1, `fl_ce_n`, `fl_oe_n` and `fl_we_n` are 1, `fl_dout_en` is 0, and `done_o` and `err_o` are 0.
- R2: An accepted request produces exactly four write strobes in this order: data 0xAA at address 0x5555, data 0x55 at address 0x2AAA, data 0xA0 at address 0x5555, then the request data at the request address.
- R3: Each write-strobe low phase lasts exactly PULSE_CYC = ceil(max(WP_NS, DS_NS) / CLK_NS) cycles. Between two writes the strobe stays high for at least WPH_NS worth of cycles. Address and data do not change while the strobe is low.
- R4: During every write, `fl_oe_n` is 1 and `fl_ce_n` is 0. The data driver `fl_dout_en` is never 1 while `fl_oe_n` is 0.
- R5: The first poll read starts HOLD_CYC = ceil(max(WPH_NS, AH_NS) / CLK_NS) cycles after the last write strobe rises. Each read holds `fl_ce_n` and `fl_oe_n` low and `fl_we_n` high at the request address. Reads repeat, with `fl_oe_n` high for GAP_CYC cycles between them, while returned bit 7 differs from request data bit 7.
- R6: When a read returns a matching bit 7, `done_o` pulses for exactly one cycle, ACC_CYC = ceil(ACC_NS / CLK_NS) cycles after that read's `fl_oe_n` fall. In the same cycle `req_ready` returns to 1 and `fl_ce_n` rises.
- R7: After POLL_LIMIT reads that all mismatch, `err_o` pulses for one cycle, `done_o` stays 0, and the block returns to idle.
- R8: A `req_valid` raised while `req_ready` is 0 is ignored. The running sequence keeps its own address and data, and no further operation follows it.
- R9: A new request presented in the cycle after `done_o` is accepted at once and runs a full sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | AW | Byte address to program |
| req_data | input | 8 | Byte to program |
| done_o | output | 1 | One-cycle pulse: byte program confirmed |
| err_o | output | 1 | One-cycle pulse: poll limit reached |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | 8 | Data driven toward the flash |
| fl_dout_en | output | 1 | Enable for the flash data driver |
| fl_din | input | 8 | Data returned by the flash |
| fl_ce_n | output | 1 | Flash chip select, active low |
| fl_oe_n | output | 1 | Flash read strobe, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |

## Verification
All bus pins are registered. They change on the clock edge that accepts a request and then on every phase boundary. With the bench timing parameters, the strobe low run is 20 cycles, the gap after the final strobe is 20 cycles, and a read lasts 7 cycles before `done_o` or `err_o` appears. The bench samples at falling edges and keeps a cycle counter. It checks these distances as exact counts, such as the first `fl_oe_n` fall landing 20 cycles after the last write-strobe rise and `done_o` landing 7 cycles after that. Where the distance depends on how long the flash model stays busy, the check is on order and count instead: the number of reads and the model being idle when `done_o` arrives.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_RGAP
  } fps_state_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fps_timer.sv
module fps_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/fps_cmd_gen.sv
module fps_cmd_gen #(
  parameter int unsigned AW = 17
) (
  input  logic [1:0]    step,
  input  logic [AW-1:0] user_addr,
  input  logic [7:0]    user_data,
  output logic [AW-1:0] cmd_addr,
  output logic [7:0]    cmd_data
);
  localparam logic [AW-1:0] UNLOCK_A = AW'(16'h5555);
  localparam logic [AW-1:0] UNLOCK_B = AW'(16'h2AAA);

  always_comb begin
    unique case (step)
      2'd0:    begin cmd_addr = UNLOCK_A;  cmd_data = 8'hAA;     end
      2'd1:    begin cmd_addr = UNLOCK_B;  cmd_data = 8'h55;     end
      2'd2:    begin cmd_addr = UNLOCK_A;  cmd_data = 8'hA0;     end
      default: begin cmd_addr = user_addr; cmd_data = user_data; end
    endcase
  end
endmodule

// File: rtl/fps_poll_ctr.sv
module fps_poll_ctr #(
  parameter int unsigned LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic last
);
  localparam int unsigned PW = $clog2(LIMIT + 1);
  localparam logic [PW-1:0] LAST_VAL = PW'(LIMIT - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (inc)    cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int unsigned AW         = 17,
  parameter int unsigned CLK_NS     = 10,
  parameter int unsigned WP_NS      = 200,
  parameter int unsigned WPH_NS     = 200,
  parameter int unsigned AH_NS      = 100,
  parameter int unsigned DS_NS      = 100,
  parameter int unsigned ACC_NS     = 70,
  parameter int unsigned GAP_NS     = 50,
  parameter int unsigned POLL_LIMIT = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dout,
  output logic          fl_dout_en,
  input  logic [7:0]    fl_din,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  localparam int unsigned PULSE_CYC = ns_to_cyc(max_u(WP_NS, DS_NS), CLK_NS);
  localparam int unsigned HOLD_CYC  = ns_to_cyc(max_u(WPH_NS, AH_NS), CLK_NS);
  localparam int unsigned ACC_CYC   = ns_to_cyc(ACC_NS, CLK_NS);
  localparam int unsigned GAP_CYC   = ns_to_cyc(GAP_NS, CLK_NS);
  localparam int unsigned MAX_CYC   = max_u(max_u(PULSE_CYC, HOLD_CYC), max_u(ACC_CYC, GAP_CYC));
  localparam int unsigned TW        = $clog2(MAX_CYC + 1);

  fps_state_e    state_q, state_d;
  logic [1:0]    step_q, step_d;
  logic [AW-1:0] uaddr_q, uaddr_d;
  logic [7:0]    udata_q, udata_d;
  logic          accept, t_zero, t_load, poll_last, bit_match;
  logic          sample, done_d, err_d;
  logic [TW-1:0] t_val;
  logic [AW-1:0] cmd_addr;
  logic [7:0]    cmd_data;

  assign accept    = req_valid && (state_q == ST_IDLE);
  assign uaddr_d   = accept ? req_addr : uaddr_q;
  assign udata_d   = accept ? req_data : udata_q;
  assign bit_match = (fl_din[7] == udata_q[7]);
  assign sample    = (state_q == ST_RACC) && t_zero;
  assign done_d    = sample && bit_match;
  assign err_d     = sample && !bit_match && poll_last;

  // phase sequencing
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid) begin state_d = ST_WSETUP; step_d = 2'd0; end
      ST_WSETUP: if (t_zero) state_d = ST_WPULSE;
      ST_WPULSE: if (t_zero) state_d = ST_WHOLD;
      ST_WHOLD:  if (t_zero) begin
                   if (step_q == 2'd3) state_d = ST_RACC;
                   else begin state_d = ST_WSETUP; step_d = step_q + 2'd1; end
                 end
      ST_RACC:   if (t_zero) state_d = (bit_match || poll_last) ? ST_IDLE : ST_RGAP;
      ST_RGAP:   if (t_zero) state_d = ST_RACC;
      default:   state_d = ST_IDLE;
    endcase
  end

  // phase length for the phase being entered
  always_comb begin
    unique case (state_d)
      ST_WPULSE: t_val = TW'(PULSE_CYC - 1);
      ST_WHOLD:  t_val = TW'(HOLD_CYC - 1);
      ST_RACC:   t_val = TW'(ACC_CYC - 1);
      ST_RGAP:   t_val = TW'(GAP_CYC - 1);
      default:   t_val = '0;
    endcase
  end
  assign t_load = (state_d != state_q);

  fps_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  fps_poll_ctr #(.LIMIT(POLL_LIMIT)) u_polls (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .inc   (sample && !bit_match),
    .last  (poll_last)
  );

  fps_cmd_gen #(.AW(AW)) u_cmd (
    .step      (step_d),
    .user_addr (uaddr_d),
    .user_data (udata_d),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data)
  );

  logic wr_phase_d;
  assign wr_phase_d = (state_d == ST_WSETUP) || (state_d == ST_WPULSE) || (state_d == ST_WHOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      step_q     <= 2'd0;
      uaddr_q    <= '0;
      udata_q    <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      fl_addr    <= '0;
      fl_dout    <= '0;
      fl_dout_en <= 1'b0;
      fl_ce_n    <= 1'b1;
      fl_oe_n    <= 1'b1;
      fl_we_n    <= 1'b1;
    end else begin
      state_q    <= state_d;
      step_q     <= step_d;
      uaddr_q    <= uaddr_d;
      udata_q    <= udata_d;
      done_o     <= done_d;
      err_o      <= err_d;
      fl_addr    <= wr_phase_d ? cmd_addr : uaddr_d;
      fl_dout    <= wr_phase_d ? cmd_data : 8'h00;
      fl_dout_en <= wr_phase_d;
      fl_ce_n    <= (state_d == ST_IDLE);
      fl_oe_n    <= (state_d != ST_RACC);
      fl_we_n    <= (state_d != ST_WPULSE);
    end
  end

  assign req_ready = (state_q == ST_IDLE);

endmodule

// File: rtl/fps_chk.sv
module fps_chk #(
  parameter int unsigned AW      = 17,
  parameter int unsigned MIN_LOW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          done_o,
  input logic          err_o,
  input logic [AW-1:0] fl_addr,
  input logic [7:0]    fl_dout,
  input logic          fl_dout_en,
  input logic          fl_ce_n,
  input logic          fl_oe_n,
  input logic          fl_we_n
);
  logic [15:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 low_run <= '0;
    else if (fl_we_n)           low_run <= '0;
    else if (low_run != 16'hFFFF) low_run <= low_run + 1'b1;
  end

  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (fl_ce_n && fl_oe_n && fl_we_n && !fl_dout_en)); // R1
  AST_WE_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(fl_we_n) |-> (low_run >= 16'(MIN_LOW))); // R3
  AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !fl_we_n |=> ($stable(fl_addr) && $stable(fl_dout))); // R3
  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !fl_we_n |-> (fl_oe_n && !fl_ce_n && fl_dout_en)); // R4
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) !fl_oe_n |-> (!fl_dout_en && fl_we_n)); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R6
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done_o && err_o)); // R7
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) err_o |=> !err_o); // R7
endmodule

bind flash_prog_seq fps_chk #(.AW(AW), .MIN_LOW(PULSE_CYC)) u_fps_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .done_o     (done_o),
  .err_o      (err_o),
  .fl_addr    (fl_addr),
  .fl_dout    (fl_dout),
  .fl_dout_en (fl_dout_en),
  .fl_ce_n    (fl_ce_n),
  .fl_oe_n    (fl_oe_n),
  .fl_we_n    (fl_we_n)
);

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb;
  localparam int AW = 17;
  localparam int PULSE = 20;   // ceil(200/10)
  localparam int HOLD  = 20;   // ceil(200/10)
  localparam int ACC   = 7;    // ceil(70/10)
  localparam int WPHC  = 20;
  localparam int LIMIT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic done_o, err_o, fl_dout_en, fl_ce_n, fl_oe_n, fl_we_n;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_dout, fl_din;

  always #5 clk = ~clk;

  flash_prog_seq #(.AW(AW), .POLL_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .done_o(done_o), .err_o(err_o),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_dout_en(fl_dout_en), .fl_din(fl_din),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // flash model and bus monitor
  int cyc = 0;
  int busy_cnt = 0;
  int model_busy = 0;
  logic [7:0] prog_q = 8'hFF;
  logic [AW-1:0] wa [4];
  logic [7:0] wd [4];
  int wl [4];
  int nwr, low_len, high_len, gap_min, oe_bad, polls, we_rise_t, oe_fall_t, done_t, done_n, err_n;
  logic pce = 1'b1, poe = 1'b1, pwe = 1'b1;

  assign fl_din = (busy_cnt != 0) ? {~prog_q[7], prog_q[6:0]} : prog_q;

  always @(negedge clk) begin
    cyc++;
    if (busy_cnt > 0) busy_cnt--;
    if (pce && !fl_ce_n) begin
      nwr = 0; gap_min = 1000; oe_bad = 0; polls = 0; oe_fall_t = -1;
      done_n = 0; err_n = 0; high_len = 0; low_len = 0;
    end
    if (!fl_we_n) begin
      low_len++;
      if (!fl_oe_n || fl_ce_n) oe_bad++;
    end
    if (fl_we_n && !fl_ce_n && nwr > 0 && nwr < 4) high_len++;
    if (!pwe && fl_we_n) begin
      if (nwr < 4) begin wa[nwr] = fl_addr; wd[nwr] = fl_dout; wl[nwr] = low_len; end
      nwr++;
      we_rise_t = cyc;
      if (nwr == 4) begin prog_q = fl_dout; busy_cnt = model_busy; end
      low_len = 0; high_len = 0;
    end
    if (pwe && !fl_we_n && nwr > 0 && high_len < gap_min) gap_min = high_len;
    if (poe && !fl_oe_n) begin polls++; if (oe_fall_t < 0) oe_fall_t = cyc; end
    if (done_o) begin done_n++; done_t = cyc; end
    if (err_o) err_n++;
    pce = fl_ce_n; poe = fl_oe_n; pwe = fl_we_n;
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!done_o && !err_o && n < 20000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "ready", req_ready, 1);
    check("R1", "bus idle", {fl_ce_n, fl_oe_n, fl_we_n, fl_dout_en}, 4'b1110);
    check("R1", "done/err", {done_o, err_o}, 0);
  endtask

  task automatic t_program(input logic [AW-1:0] a, input logic [7:0] d, input int busy);
    model_busy = busy;
    send(a, d);
    wait_end();
    check("R2", "write count", nwr, 4);
    check("R2", "w0", {wa[0], wd[0]}, {17'h05555, 8'hAA});
    check("R2", "w1", {wa[1], wd[1]}, {17'h02AAA, 8'h55});
    check("R2", "w2", {wa[2], wd[2]}, {17'h05555, 8'hA0});
    check("R2", "w3", {wa[3], wd[3]}, {a, d});
    for (int i = 0; i < 4; i++) check("R3", "we low width", wl[i], PULSE);
    check("R3", "we high gap ok", gap_min >= WPHC, 1);
    check("R4", "oe high/ce low during writes", oe_bad, 0);
    check("R5", "first read after last rise", oe_fall_t - we_rise_t, HOLD);
    check("R6", "done once", done_n, 1);
    check("R6", "no err", err_n, 0);
    check("R6", "ready back", req_ready, 1);
    check("R1", "ce released", fl_ce_n, 1);
  endtask

  task automatic t_fast();
    t_program(17'h01234, 8'h3C, 0);
    check("R6", "done latency from oe fall", done_t - oe_fall_t, ACC);
    check("R5", "single read", polls, 1);
  endtask

  task automatic t_poll(input logic [7:0] d);
    t_program(17'h1F00F, d, 60);
    check("R5", "several reads", polls >= 2, 1);
    check("R5", "done only when model idle", busy_cnt, 0);
  endtask

  task automatic t_timeout();
    model_busy = 1000000;
    send(17'h00042, 8'h81);
    wait_end();
    check("R7", "err once", err_n, 1);
    check("R7", "no done", done_n, 0);
    check("R7", "reads made", polls, LIMIT);
    check("R7", "idle after err", {req_ready, fl_ce_n}, 2'b11);
    busy_cnt = 0;
  endtask

  task automatic t_ignore();
    int extra = 0;
    model_busy = 0;
    send(17'h00777, 8'h12);
    repeat (30) @(negedge clk);
    check("R8", "ready low while busy", req_ready, 0);
    req_valid = 1'b1; req_addr = 17'h1AAAA; req_data = 8'hEE;
    @(negedge clk);
    req_valid = 1'b0;
    wait_end();
    check("R8", "user write kept", {wa[3], wd[3]}, {17'h00777, 8'h12});
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (!fl_ce_n) extra++; end
    check("R8", "no extra op", extra, 0);
  endtask

  task automatic t_back2back();
    int gap = 0;
    model_busy = 0;
    send(17'h00100, 8'h55);
    while (!done_o) @(negedge clk);
    req_valid = 1'b1; req_addr = 17'h00200; req_data = 8'hAA;
    while (fl_ce_n && gap < 10) begin @(negedge clk); gap++; end
    req_valid = 1'b0;
    check("R9", "restart delay", gap, 1);
    wait_end();
    check("R9", "second op data", {wa[3], wd[3]}, {17'h00200, 8'hAA});
    check("R9", "second done", done_n, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fast();
    t_poll(8'h5A);
    t_poll(8'hC3);
    t_timeout();
    t_ignore();
    t_back2back();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule